// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block hands out and reclaims 256-byte pages of a shared packet memory used by both the transmit and the receive side of a network controller. A host drives a byte-wide command port: each command word carries an operation code in its top three bits. The operations are allocate, full reset, drop the receive head, release the receive head, free a packet by number, queue for transmit and flush the transmit queue. A separate packet-number register names the packet that the free and queue-for-transmit operations act on. A packet occupies a run of adjacent pages, and its packet number is the index of its first page.

Allocation is answered one cycle after the command. A result byte either holds the granted packet number or has its top bit set to flag failure, and a one-cycle done pulse accompanies the answer. Two small queues of 7-bit packet numbers connect the allocator to a MAC. Received packet numbers are pushed in by the MAC and taken out by the host. Packets queued for transmit are taken out by the MAC. A queue-heads word and a memory-information word let the host watch the heads of both queues and the page usage.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset the result byte is 0x80, the queue-heads word is 0x8080, the memory-information word holds the page total in both bytes (0x1010 for 16 pages), `cmd_status` is 0 and both overrun flags are low.
- R2: A command whose bits 7:5 are 3'b001 asks for (bits 4:0 + 1) pages. The request takes the lowest-numbered run of that many adjacent free pages. One cycle after the command, `alloc_done` is high for exactly one cycle, and the result byte holds bit 7 = 0 with the first page index in bits 6:0. The free count in the high byte of the memory-information word drops by the size of the run.
- R3: If no run of adjacent free pages is long enough, or the request exceeds 2^RUN_W pages, the result byte becomes 0x80 with the same done pulse, and no page is taken.
- R4: A command with bits 7:5 = 3'b110 appends the packet-number register to the transmit queue. Queue-heads bits 6:0 show the transmit head (0 when empty) and bit 7 is set when the transmit queue is empty.
- R5: `rx_push` appends `rx_push_pnum` to the receive queue in arrival order. Queue-heads bits 14:8 show the receive head (0 when empty) and bit 15 is set when the receive queue is empty.
- R6: Code 3'b011 removes the receive head and leaves its pages allocated. On an empty receive queue it has no effect.
- R7: Code 3'b100 removes the receive head and frees its pages. `cmd_status` bit 0 reads 1 in the cycle after the command and 0 once the pages are back in the free count one cycle later. On an empty receive queue nothing happens and the bit stays 0.
- R8: Code 3'b101 frees the pages of the packet named by the packet-number register, with the same one-cycle busy indication as R7. A number that is not a live packet frees nothing.
- R9: Code 3'b010 empties both queues, marks every page free, sets the result byte to 0x80 and clears both overrun flags, all at the next clock edge.
- R10: Code 3'b111 empties the transmit queue and clears its overrun flag. The receive queue and the page usage are left unchanged.
- R11: A push into a full queue (depth QDEPTH) is dropped, and that queue's overrun flag is set and stays set until R9 (or R10 for transmit).
- R12: `tx_pop` removes the transmit head shown on `tx_head_pnum` while `tx_head_valid` is high. A pop from an empty queue has no effect on later queue contents.
- R13: A command with bits 7:5 = 3'b000 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command word: op code in 7:5, page count minus one in 4:0 |
| pnr_we | input | 1 | Packet-number register write strobe |
| pnr_wdata | input | 7 | Packet-number register write data |
| pnr_q | output | 7 | Packet-number register contents |
| cmd_status | output | 8 | Command register read value; bit 0 is busy |
| alloc_result | output | 8 | Allocation result: bit 7 fail, bits 6:0 packet number |
| alloc_done | output | 1 | One-cycle pulse when the allocation result is updated |
| fifo_ports | output | 16 | Queue heads: RX empty, RX head, TX empty, TX head |
| mem_info | output | 16 | Free pages in 15:8, total pages in 7:0 |
| rx_push | input | 1 | MAC pushes a received packet number |
| rx_push_pnum | input | 7 | Received packet number |
| tx_pop | input | 1 | MAC takes the transmit head |
| tx_head_valid | output | 1 | Transmit queue holds an entry |
| tx_head_pnum | output | 7 | Transmit queue head |
| rx_overrun | output | 1 | Sticky: a receive push was dropped |
| tx_overrun | output | 1 | Sticky: a transmit enqueue was dropped |

## Verification
The assertions assume that the host issues at most one command per cycle and does not write the packet-number register in the same cycle as a command that reads it. They also assume that the host frees only packet numbers that the allocator granted, so that no run of pages is freed twice. The bench drives every input on the falling edge, sends one command at a time, waits out the busy cycle of a release before the next command, and frees only packets that the allocation scoreboard has confirmed. It also exercises deliberately harmless misuse that the requirements define: a pop from an empty queue, a free of a dead number and a push into a full queue.

// File: rtl/pkt_alloc_pkg.sv
package pkt_alloc_pkg;

    localparam int PNUM_W  = 7;
    localparam int ASIZE_W = 5;
    localparam logic [7:0] RESULT_FAIL = 8'h80;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_ALLOC      = 3'd1,
        OP_RESET      = 3'd2,
        OP_RX_DROP    = 3'd3,
        OP_RX_RELEASE = 3'd4,
        OP_FREE_PNR   = 3'd5,
        OP_TX_ENQ     = 3'd6,
        OP_TX_RESET   = 3'd7
    } mmu_op_e;

    typedef struct packed {
        logic              empty;
        logic [PNUM_W-1:0] head;
    } qhead_t;

    typedef struct packed {
        logic               pend;
        logic [ASIZE_W-1:0] m1;
    } alloc_req_t;

    typedef struct packed {
        logic              busy;
        logic [PNUM_W-1:0] pnum;
    } free_req_t;

    function automatic mmu_op_e decode_op(logic [7:0] word);
        return mmu_op_e'(word[7:5]);
    endfunction

    function automatic qhead_t make_head(logic valid, logic [PNUM_W-1:0] pnum);
        qhead_t h;
        h.empty = !valid;
        h.head  = valid ? pnum : '0;
        return h;
    endfunction

endpackage

// File: rtl/pa_pnum_fifo.sv
module pa_pnum_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         valid,
    output logic         overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, empty, do_push, do_pop;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];
    assign valid   = !empty;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop) count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
            if (push && !do_push) overrun <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !clr) |=> (count == CW'(DEPTH) && overrun));

    assert_idle_pop_R12: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !clr) |=> !valid);

endmodule

// File: rtl/pa_page_pool.sv
module pa_page_pool
    import pkt_alloc_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int RUN_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 alloc_go,
    input  logic [ASIZE_W-1:0]   alloc_m1,
    input  logic                 free_go,
    input  logic [PNUM_W-1:0]    free_pnum,
    output logic                 grant_ok,
    output logic [PNUM_W-1:0]    grant_pnum,
    output logic [NUM_PAGES-1:0] used_map,
    output logic [7:0]           free_cnt
);
    localparam int MAX_RUN = 1 << RUN_W;
    localparam int LEN_W   = RUN_W + 1;
    localparam int PAD     = NUM_PAGES + MAX_RUN;

    logic [NUM_PAGES-1:0] used_q;
    logic [LEN_W-1:0]     len_q [NUM_PAGES];
    logic [PAD-1:0]       used_pad;
    logic [ASIZE_W:0]     want;
    logic [NUM_PAGES-1:0] fits, alloc_mask, free_mask;
    logic [LEN_W-1:0]     sel_len;

    assign used_pad = {{MAX_RUN{1'b1}}, used_q};
    assign want     = {1'b0, alloc_m1} + (ASIZE_W+1)'(1);
    assign used_map = used_q;

    for (genvar s = 0; s < NUM_PAGES; s++) begin : g_fit
        logic fit_s;
        always_comb begin
            fit_s = (int'(want) <= MAX_RUN);
            for (int k = 0; k < MAX_RUN; k++) begin
                if (k < int'(want) && used_pad[s + k]) fit_s = 1'b0;
            end
        end
        assign fits[s] = fit_s;
    end

    always_comb begin
        grant_ok   = 1'b0;
        grant_pnum = '0;
        for (int s = NUM_PAGES - 1; s >= 0; s--) begin
            if (fits[s]) begin
                grant_ok   = 1'b1;
                grant_pnum = PNUM_W'(s);
            end
        end
    end

    always_comb begin
        sel_len = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (PNUM_W'(i) == free_pnum) sel_len = len_q[i];
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_PAGES; i++) begin
            alloc_mask[i] = alloc_go && grant_ok && (i >= int'(grant_pnum))
                            && (i < int'(grant_pnum) + int'(want));
            free_mask[i]  = free_go && (i >= int'(free_pnum))
                            && (i < int'(free_pnum) + int'(sel_len));
        end
    end

    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (!used_q[i]) free_cnt = free_cnt + 8'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            used_q <= '0;
            for (int i = 0; i < NUM_PAGES; i++) len_q[i] <= '0;
        end else begin
            used_q <= (used_q & ~free_mask) | alloc_mask;
            for (int i = 0; i < NUM_PAGES; i++) begin
                if (free_go && PNUM_W'(i) == free_pnum)
                    len_q[i] <= '0;
                else if (alloc_go && grant_ok && PNUM_W'(i) == grant_pnum)
                    len_q[i] <= LEN_W'(want);
            end
        end
    end

    assert_no_double_take_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_go && grant_ok && !clr) |-> ((used_q & alloc_mask) == '0));

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
    import pkt_alloc_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int RUN_W     = 3,
    parameter int QDEPTH    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_wdata,
    input  logic              pnr_we,
    input  logic [PNUM_W-1:0] pnr_wdata,
    output logic [PNUM_W-1:0] pnr_q,
    output logic [7:0]        cmd_status,
    output logic [7:0]        alloc_result,
    output logic              alloc_done,
    output logic [15:0]       fifo_ports,
    output logic [15:0]       mem_info,
    input  logic              rx_push,
    input  logic [PNUM_W-1:0] rx_push_pnum,
    input  logic              tx_pop,
    output logic              tx_head_valid,
    output logic [PNUM_W-1:0] tx_head_pnum,
    output logic              rx_overrun,
    output logic              tx_overrun
);
    localparam logic [7:0] TOTAL_PAGES = 8'(NUM_PAGES);

    mmu_op_e              op;
    logic                 do_alloc, do_reset, do_rxpop, do_rel, do_free, do_enq, do_txrst;
    alloc_req_t           alloc_q;
    free_req_t            free_q;
    logic                 rx_valid;
    logic [PNUM_W-1:0]    rx_head;
    logic                 grant_ok;
    logic [PNUM_W-1:0]    grant_pnum;
    logic [NUM_PAGES-1:0] used_map;
    logic [7:0]           free_cnt;
    qhead_t               rx_field, tx_field;

    assign op       = decode_op(cmd_wdata);
    assign do_alloc = cmd_we && (op == OP_ALLOC);
    assign do_reset = cmd_we && (op == OP_RESET);
    assign do_rxpop = cmd_we && (op == OP_RX_DROP || op == OP_RX_RELEASE);
    assign do_rel   = cmd_we && (op == OP_RX_RELEASE);
    assign do_free  = cmd_we && (op == OP_FREE_PNR);
    assign do_enq   = cmd_we && (op == OP_TX_ENQ);
    assign do_txrst = cmd_we && (op == OP_TX_RESET);

    pa_pnum_fifo #(.DEPTH(QDEPTH), .W(PNUM_W)) i_rxq (
        .clk(clk), .rst(rst), .clr(do_reset),
        .push(rx_push), .din(rx_push_pnum), .pop(do_rxpop),
        .head(rx_head), .valid(rx_valid), .overrun(rx_overrun)
    );

    pa_pnum_fifo #(.DEPTH(QDEPTH), .W(PNUM_W)) i_txq (
        .clk(clk), .rst(rst), .clr(do_reset || do_txrst),
        .push(do_enq), .din(pnr_q), .pop(tx_pop),
        .head(tx_head_pnum), .valid(tx_head_valid), .overrun(tx_overrun)
    );

    pa_page_pool #(.NUM_PAGES(NUM_PAGES), .RUN_W(RUN_W)) i_pool (
        .clk(clk), .rst(rst), .clr(do_reset),
        .alloc_go(alloc_q.pend), .alloc_m1(alloc_q.m1),
        .free_go(free_q.busy), .free_pnum(free_q.pnum),
        .grant_ok(grant_ok), .grant_pnum(grant_pnum),
        .used_map(used_map), .free_cnt(free_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pnr_q        <= '0;
            alloc_q      <= '0;
            free_q       <= '0;
            alloc_result <= RESULT_FAIL;
            alloc_done   <= 1'b0;
        end else begin
            if (pnr_we) pnr_q <= pnr_wdata;
            alloc_done <= alloc_q.pend && !do_reset;
            if (do_reset)
                alloc_result <= RESULT_FAIL;
            else if (alloc_q.pend)
                alloc_result <= grant_ok ? {1'b0, grant_pnum} : RESULT_FAIL;
            if (do_reset)
                alloc_q <= '0;
            else
                alloc_q <= '{pend: do_alloc, m1: cmd_wdata[ASIZE_W-1:0]};
            if (do_reset)
                free_q <= '0;
            else if (do_rel && rx_valid)
                free_q <= '{busy: 1'b1, pnum: rx_head};
            else if (do_free)
                free_q <= '{busy: 1'b1, pnum: pnr_q};
            else
                free_q.busy <= 1'b0;
        end
    end

    assign rx_field   = make_head(rx_valid, rx_head);
    assign tx_field   = make_head(tx_head_valid, tx_head_pnum);
    assign fifo_ports = {rx_field, tx_field};
    assign mem_info   = {free_cnt, TOTAL_PAGES};
    assign cmd_status = {7'b0, free_q.busy};

    assert_reset_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        do_reset |=> (alloc_result == RESULT_FAIL && fifo_ports == 16'h8080
                      && mem_info[15:8] == TOTAL_PAGES && !rx_overrun && !tx_overrun));

    assert_tx_flush_R10: assert property (@(posedge clk) disable iff (rst)
        do_txrst |=> (fifo_ports[7] && !tx_overrun));

    assert_busy_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_status[0] && !do_rel && !do_free) |=> !cmd_status[0]);

    assert_grant_is_used_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_done && !alloc_result[7])
            |-> |(used_map & (NUM_PAGES'(1) << alloc_result[PNUM_W-1:0])));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_done && !cmd_we) |=> !alloc_done);

endmodule

// File: tb/test_pkt_page_alloc.sv
module test_pkt_page_alloc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_wdata = '0;
    logic        pnr_we = 1'b0;
    logic [6:0]  pnr_wdata = '0;
    logic [6:0]  pnr_q;
    logic [7:0]  cmd_status, alloc_result;
    logic        alloc_done;
    logic [15:0] fifo_ports, mem_info;
    logic        rx_push = 1'b0;
    logic [6:0]  rx_push_pnum = '0;
    logic        tx_pop = 1'b0;
    logic        tx_head_valid;
    logic [6:0]  tx_head_pnum;
    logic        rx_overrun, tx_overrun;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_val [$];
    string      exp_tag [$];

    always #4 clk = ~clk;

    pkt_page_alloc i_pkt_page_alloc (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .pnr_we(pnr_we), .pnr_wdata(pnr_wdata), .pnr_q(pnr_q),
        .cmd_status(cmd_status), .alloc_result(alloc_result), .alloc_done(alloc_done),
        .fifo_ports(fifo_ports), .mem_info(mem_info),
        .rx_push(rx_push), .rx_push_pnum(rx_push_pnum),
        .tx_pop(tx_pop), .tx_head_valid(tx_head_valid), .tx_head_pnum(tx_head_pnum),
        .rx_overrun(rx_overrun), .tx_overrun(tx_overrun)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_cmd(logic [7:0] c);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = c;
        @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
    endtask

    task automatic set_pnr(logic [6:0] p);
        @(negedge clk); pnr_we = 1'b1; pnr_wdata = p;
        @(negedge clk); pnr_we = 1'b0;
    endtask

    task automatic mac_rx(logic [6:0] p);
        @(negedge clk); rx_push = 1'b1; rx_push_pnum = p;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic mac_tx_pop();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic enqueue(logic [6:0] p);
        set_pnr(p);
        do_cmd(8'hC0);
    endtask

    // driver side of the allocation scoreboard
    task automatic alloc_req(logic [4:0] m1, logic [7:0] exp, string tag);
        exp_val.push_back(exp);
        exp_tag.push_back(tag);
        do_cmd({3'b001, m1});
        idle(1);
    endtask

    // monitor side of the allocation scoreboard
    always @(negedge clk) begin
        if (!rst && alloc_done) begin
            if (exp_val.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R13: actual=alloc_done expected=no completion");
            end else begin
                automatic logic [7:0] e = exp_val.pop_front();
                automatic string t = exp_tag.pop_front();
                chk(t, 32'(alloc_result), 32'(e));
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk("R1 result", 32'(alloc_result), 32'h80);
        chk("R1 fifo", 32'(fifo_ports), 32'h8080);
        chk("R1 mem", 32'(mem_info), 32'h1010);
        chk("R1 status", 32'({cmd_status, rx_overrun, tx_overrun}), 32'h0);

        // R2 allocations take lowest runs
        alloc_req(5'd1, 8'h00, "R2 alloc2");
        chk("R2 mem", 32'(mem_info), 32'h0E10);
        idle(1);
        chk("R2 pulse", 32'(alloc_done), 32'h0);
        alloc_req(5'd2, 8'h02, "R2 alloc3");
        alloc_req(5'd7, 8'h05, "R2 alloc8");
        chk("R2 mem8", 32'(mem_info), 32'h0310);
        // R3 not enough adjacent pages
        alloc_req(5'd3, 8'h80, "R3 fail");
        chk("R3 mem", 32'(mem_info), 32'h0310);

        // R8 free by number
        set_pnr(7'd2);
        do_cmd(8'hA0);
        chk("R8 busy", 32'(cmd_status), 32'h01);
        idle(1);
        chk("R8 idle", 32'(cmd_status), 32'h00);
        chk("R8 mem", 32'(mem_info), 32'h0610);
        alloc_req(5'd2, 8'h02, "R2 reuse");

        // R5 receive queue
        mac_rx(7'd5);
        mac_rx(7'd0);
        chk("R5 fifo", 32'(fifo_ports), 32'h0580);
        // R6 remove keeps pages
        do_cmd(8'h60);
        chk("R6 fifo", 32'(fifo_ports), 32'h0080);
        chk("R6 mem", 32'(mem_info), 32'h0310);
        // R7 release frees pages
        do_cmd(8'h80);
        chk("R7 busy", 32'(cmd_status), 32'h01);
        chk("R7 fifo", 32'(fifo_ports), 32'h8080);
        idle(1);
        chk("R7 mem", 32'(mem_info), 32'h0510);
        do_cmd(8'h80);
        chk("R7 empty busy", 32'(cmd_status), 32'h00);
        do_cmd(8'h60);
        idle(1);
        chk("R6 empty", 32'({fifo_ports, mem_info}), 32'h80800510);

        // R4 transmit queue
        enqueue(7'd5);
        enqueue(7'd2);
        chk("R4 fifo", 32'(fifo_ports), 32'h8005);
        // R12 MAC pop
        chk("R12 head", 32'({tx_head_valid, tx_head_pnum}), 32'h85);
        mac_tx_pop();
        chk("R12 next", 32'(fifo_ports), 32'h8002);
        // R11 transmit overflow
        enqueue(7'd7);
        enqueue(7'd8);
        enqueue(7'd9);
        chk("R11 no ovr", 32'(tx_overrun), 32'h0);
        enqueue(7'd10);
        chk("R11 tx ovr", 32'(tx_overrun), 32'h1);
        chk("R11 head", 32'(tx_head_pnum), 32'h02);
        for (int i = 0; i < 4; i++) begin
            automatic logic [6:0] e = (i == 0) ? 7'd2 : 7'(6 + i);
            chk("R12 order", 32'(tx_head_pnum), 32'(e));
            mac_tx_pop();
        end
        chk("R12 drained", 32'({tx_head_valid, fifo_ports[7]}), 32'h1);
        mac_tx_pop();
        // R11 receive overflow
        for (int i = 11; i < 16; i++) mac_rx(7'(i));
        chk("R11 rx ovr", 32'(rx_overrun), 32'h1);
        chk("R11 rx head", 32'(fifo_ports[15:8]), 32'h0B);

        // R10 transmit flush
        enqueue(7'd3);
        chk("R12 after idle pop", 32'(fifo_ports), 32'h0B03);
        do_cmd(8'hE0);
        chk("R10 fifo", 32'(fifo_ports), 32'h0B80);
        chk("R10 flags", 32'({rx_overrun, tx_overrun}), 32'h2);
        chk("R10 mem", 32'(mem_info), 32'h0510);

        // R13 no-op
        do_cmd(8'h00);
        idle(1);
        chk("R13 state", 32'({fifo_ports, mem_info}), 32'h0B800510);
        chk("R13 result", 32'(alloc_result), 32'h02);

        // R9 full reset
        do_cmd(8'h40);
        chk("R9 result", 32'(alloc_result), 32'h80);
        chk("R9 fifo", 32'(fifo_ports), 32'h8080);
        chk("R9 mem", 32'(mem_info), 32'h1010);
        chk("R9 flags", 32'({rx_overrun, tx_overrun}), 32'h0);

        // R3 oversize and exact fill
        alloc_req(5'd8, 8'h80, "R3 oversize");
        alloc_req(5'd7, 8'h00, "R2 fill lo");
        alloc_req(5'd7, 8'h08, "R2 fill hi");
        chk("R2 full", 32'(mem_info), 32'h0010);
        alloc_req(5'd0, 8'h80, "R3 full");
        // R8 dead number frees nothing
        set_pnr(7'd127);
        do_cmd(8'hA0);
        idle(1);
        chk("R8 dead", 32'(mem_info), 32'h0010);

        idle(2);
        chk("R2 scoreboard drained", 32'(exp_val.size()), 32'h0);
        summary();
    end
endmodule